// File: doc/BRIEF.md
# Flash Page Programmer with Read-Back Verify

This block writes one page of bytes from a local source buffer into a byte-wide parallel flash device and then checks the result by reading the page back. Each programming attempt opens with a three-write command prefix that unlocks program mode. The data bytes follow on consecutive cycles, and bytes holding the erased value 0xFF are skipped. The block then hands the address of the last byte written to an external completion detector and waits for it to signal that the device is idle.

Verification reads the page from index 0 and stops at the first byte that differs from the source. A mismatch starts a new attempt at that index instead of at the page start. When the retry budget runs out, the block reports failure together with the page number. The page number is the page base address divided by the page size. A page made entirely of 0xFF bytes causes no bus writes and no completion wait, and it still goes through verification.

The source buffer and the flash read path are both combinational: the data is valid in the same cycle as the index or read strobe. The page base must be aligned to the page size.

Top module: `flash_page_prog`

## Requirements
- R1: After reset, `done`, `fail`, `fl_we`, `fl_re` and `poll_req` are all 0.
- R2: Each attempt that writes data opens with three write cycles in a row: 0xAA at address 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555. The first data write follows in the very next cycle.
- R3: A source byte at index i that is not 0xFF is written once per pass with address `page_base + i` and that byte as data. A byte equal to 0xFF is never written, and the index still moves past it.
- R4: The command prefix is issued exactly once per attempt, just before the first byte of that attempt that is not 0xFF.
- R5: After a burst that wrote at least one byte, `poll_req` rises with `poll_addr` equal to the address of the last byte written. Both stay unchanged until `poll_ack`, and no flash read or write happens in the meantime.
- R6: A page whose bytes are all 0xFF completes with no flash write and no completion wait, and all PAGE_BYTES bytes are still read back.
- R7: Verify reads run in ascending index order starting at 0, one per cycle, and stop at the first byte whose read value differs from the source.
- R8: After a mismatch at index k, the next attempt writes nothing below index k. Its first write is at index k when that source byte is not 0xFF.
- R9: At most MAX_RETRY (default 16) retries follow the first attempt. A mismatch seen while the budget is spent ends the page with `fail` = 1 and `fail_page` = `page_base / PAGE_BYTES`. A page that passes on its last allowed attempt reports `fail` = 0.
- R10: `done` is a one-cycle pulse, issued once per page. `fail` is valid in the same cycle: 0 when every byte matched, 1 on exhaustion.
- R11: A `start` seen while a page is in progress has no effect. The retry count starts from zero at every accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a page; accepted only when idle |
| page_base | input | ADDR_W | Flash address of the page's first byte, aligned to PAGE_BYTES |
| src_idx | output | log2(PAGE_BYTES) | Index into the source buffer |
| src_data | input | 8 | Source byte at `src_idx`, same cycle |
| fl_we | output | 1 | Flash write strobe, one byte per cycle |
| fl_re | output | 1 | Flash read strobe |
| fl_addr | output | ADDR_W | Flash address for a write or read |
| fl_wdata | output | 8 | Flash write data |
| fl_rdata | input | 8 | Flash read data, same cycle as `fl_re` |
| poll_req | output | 1 | Request to the completion detector |
| poll_addr | output | ADDR_W | Address for the detector to poll |
| poll_ack | input | 1 | Detector reports the device idle |
| done | output | 1 | One-cycle end-of-page pulse |
| fail | output | 1 | Page result; 1 = verify failed after all retries |
| fail_page | output | ADDR_W - log2(PAGE_BYTES) | Page number of the current page |

## Verification
Two decisions can land in the same verify cycle: a byte mismatch, and the retry budget reaching its limit. The block must then report failure instead of opening another attempt. The bench provokes this in two ways. A byte that never programs must fail after exactly seventeen command prefixes. A byte that stays unprogrammed through its first sixteen programming attempts must still pass on its final attempt. A second collision, a `start` arriving in the middle of a retried page, is checked by confirming that every write stays inside the original page and that the attempt count is unchanged.

// File: rtl/fpp_pkg.sv
// Shared types and constants for the flash page programmer.
// Assumes a byte-wide flash device whose command addresses fit in 15 bits.
package fpp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UNLK0,
        ST_UNLK1,
        ST_UNLK2,
        ST_BURST,
        ST_POLL,
        ST_VERIFY
    } fpp_state_e;

    localparam logic [7:0]  ERASED_BYTE = 8'hFF;
    localparam logic [7:0]  CMD_FIRST   = 8'hAA;
    localparam logic [7:0]  CMD_SECOND  = 8'h55;
    localparam logic [7:0]  CMD_PROGRAM = 8'hA0;
    localparam logic [15:0] CMD_ADDR_A  = 16'h5555;
    localparam logic [15:0] CMD_ADDR_B  = 16'h2AAA;

endpackage

// File: rtl/fpp_unlock_seq.sv
// Command prefix lookup: maps step 0..2 to the address/data of each
// write in the program-unlock prefix. Pure combinational; assumes
// ADDR_W >= 15 so the command addresses are representable.
module fpp_unlock_seq
    import fpp_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [1:0]        step,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [7:0]        cmd_data
);

    // Select the address and data of the current prefix step.
    always_comb begin
        case (step)
            2'd0: begin
                cmd_addr = ADDR_W'(CMD_ADDR_A);
                cmd_data = CMD_FIRST;
            end
            2'd1: begin
                cmd_addr = ADDR_W'(CMD_ADDR_B);
                cmd_data = CMD_SECOND;
            end
            default: begin
                cmd_addr = ADDR_W'(CMD_ADDR_A);
                cmd_data = CMD_PROGRAM;
            end
        endcase
    end

endmodule

// File: rtl/fpp_page_cursor.sv
// Byte index within the page and the flash address derived from it.
// Assumes PAGE_BYTES is a power of two, at least 2, and the base aligned.
module fpp_page_cursor #(
    parameter int ADDR_W     = 16,
    parameter int PAGE_BYTES = 16,
    localparam int IDX_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rewind,
    input  logic              step,
    input  logic [ADDR_W-1:0] base,
    output logic [IDX_W-1:0]  idx,
    output logic              last,
    output logic [ADDR_W-1:0] addr
);

    logic [IDX_W-1:0] idx_q;

    // Hold the index; rewind wins over step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (rewind) begin
            idx_q <= '0;
        end else if (step) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // Expose index, end-of-page flag and byte address.
    always_comb begin
        idx  = idx_q;
        last = (idx_q == IDX_W'(PAGE_BYTES - 1));
        addr = base + ADDR_W'(idx_q);
    end

endmodule

// File: rtl/fpp_retry_ctr.sv
// Counts retries of the current page and flags when the budget is spent.
// Assumes clear and bump are never asserted together.
module fpp_retry_ctr #(
    parameter int MAX_RETRY = 16,
    localparam int RET_W    = $clog2(MAX_RETRY + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bump,
    output logic full
);

    logic [RET_W-1:0] cnt_q;

    // Retry count, cleared at page start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (bump && (cnt_q != RET_W'(MAX_RETRY))) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Budget exhausted flag.
    always_comb full = (cnt_q == RET_W'(MAX_RETRY));

endmodule

// File: rtl/flash_page_prog.sv
// Flash page programmer with read-back verify and bounded retry.
// Writes one page from a source buffer, skipping erased (0xFF) bytes,
// waits for the external completion detector, verifies, and retries
// from the first mismatching index. Assumes page_base is aligned to
// PAGE_BYTES, and that src_data and fl_rdata are valid combinationally.
module flash_page_prog
    import fpp_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int PAGE_BYTES = 16,
    parameter int MAX_RETRY  = 16,
    localparam int IDX_W     = $clog2(PAGE_BYTES),
    localparam int PG_W      = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] page_base,
    output logic [IDX_W-1:0]  src_idx,
    input  logic [7:0]        src_data,
    output logic              fl_we,
    output logic              fl_re,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [7:0]        fl_wdata,
    input  logic [7:0]        fl_rdata,
    output logic              poll_req,
    output logic [ADDR_W-1:0] poll_addr,
    input  logic              poll_ack,
    output logic              done,
    output logic              fail,
    output logic [PG_W-1:0]   fail_page
);

    fpp_state_e        state_q, state_d;
    logic [ADDR_W-1:0] base_q, base_d;
    logic [ADDR_W-1:0] last_wr_q, last_wr_d;
    logic              unlocked_q, unlocked_d;
    logic              done_q, done_d;
    logic              fail_q, fail_d;

    logic              cur_rewind, cur_step, cur_last;
    logic [IDX_W-1:0]  cur_idx;
    logic [ADDR_W-1:0] cur_addr;
    logic              rty_clear, rty_bump, rty_full;
    logic [1:0]        cmd_step;
    logic [ADDR_W-1:0] cmd_addr;
    logic [7:0]        cmd_data;
    logic              byte_erased, mismatch;

    fpp_page_cursor #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_cursor (
        .clk    (clk),
        .rst_n  (rst_n),
        .rewind (cur_rewind),
        .step   (cur_step),
        .base   (base_q),
        .idx    (cur_idx),
        .last   (cur_last),
        .addr   (cur_addr)
    );

    fpp_retry_ctr #(.MAX_RETRY(MAX_RETRY)) u_retry (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (rty_clear),
        .bump  (rty_bump),
        .full  (rty_full)
    );

    fpp_unlock_seq #(.ADDR_W(ADDR_W)) u_unlock (
        .step     (cmd_step),
        .cmd_addr (cmd_addr),
        .cmd_data (cmd_data)
    );

    // Prefix step follows the unlock state.
    always_comb begin
        case (state_q)
            ST_UNLK1: cmd_step = 2'd1;
            ST_UNLK2: cmd_step = 2'd2;
            default:  cmd_step = 2'd0;
        endcase
    end

    // Byte classification for the burst and verify phases.
    always_comb begin
        byte_erased = (src_data == ERASED_BYTE);
        mismatch    = (fl_rdata != src_data);
    end

    // Next-state and bus control.
    always_comb begin
        state_d    = state_q;
        base_d     = base_q;
        last_wr_d  = last_wr_q;
        unlocked_d = unlocked_q;
        done_d     = 1'b0;
        fail_d     = fail_q;
        cur_rewind = 1'b0;
        cur_step   = 1'b0;
        rty_clear  = 1'b0;
        rty_bump   = 1'b0;
        fl_we      = 1'b0;
        fl_re      = 1'b0;
        fl_addr    = cur_addr;
        fl_wdata   = cmd_data;
        case (state_q)
            ST_IDLE: begin
                if (start) begin
                    base_d     = page_base;
                    cur_rewind = 1'b1;
                    rty_clear  = 1'b1;
                    unlocked_d = 1'b0;
                    fail_d     = 1'b0;
                    state_d    = ST_BURST;
                end
            end
            ST_UNLK0, ST_UNLK1: begin
                fl_we   = 1'b1;
                fl_addr = cmd_addr;
                state_d = (state_q == ST_UNLK0) ? ST_UNLK1 : ST_UNLK2;
            end
            ST_UNLK2: begin
                fl_we      = 1'b1;
                fl_addr    = cmd_addr;
                unlocked_d = 1'b1;
                state_d    = ST_BURST;
            end
            ST_BURST: begin
                if (!byte_erased && !unlocked_q) begin
                    state_d = ST_UNLK0;
                end else begin
                    if (!byte_erased) begin
                        fl_we     = 1'b1;
                        fl_wdata  = src_data;
                        last_wr_d = cur_addr;
                    end
                    if (cur_last) begin
                        cur_rewind = 1'b1;
                        state_d    = unlocked_q ? ST_POLL : ST_VERIFY;
                    end else begin
                        cur_step = 1'b1;
                    end
                end
            end
            ST_POLL: begin
                if (poll_ack) begin
                    state_d = ST_VERIFY;
                end
            end
            ST_VERIFY: begin
                fl_re = 1'b1;
                if (mismatch) begin
                    if (rty_full) begin
                        done_d  = 1'b1;
                        fail_d  = 1'b1;
                        state_d = ST_IDLE;
                    end else begin
                        rty_bump   = 1'b1;
                        unlocked_d = 1'b0;
                        state_d    = ST_BURST;
                    end
                end else if (cur_last) begin
                    done_d     = 1'b1;
                    fail_d     = 1'b0;
                    cur_rewind = 1'b1;
                    state_d    = ST_IDLE;
                end else begin
                    cur_step = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            base_q     <= '0;
            last_wr_q  <= '0;
            unlocked_q <= 1'b0;
            done_q     <= 1'b0;
            fail_q     <= 1'b0;
        end else begin
            state_q    <= state_d;
            base_q     <= base_d;
            last_wr_q  <= last_wr_d;
            unlocked_q <= unlocked_d;
            done_q     <= done_d;
            fail_q     <= fail_d;
        end
    end

    // Output assignments.
    always_comb begin
        src_idx   = cur_idx;
        poll_req  = (state_q == ST_POLL);
        poll_addr = last_wr_q;
        done      = done_q;
        fail      = fail_q;
        fail_page = base_q[ADDR_W-1:IDX_W];
    end

endmodule

// File: rtl/fpp_checker.sv
// Protocol checks for flash_page_prog, attached by bind.
// Observes ports plus the FSM state and retry-exhausted flag.
module fpp_checker
    import fpp_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fl_we,
    input logic              fl_re,
    input logic [7:0]        fl_wdata,
    input logic              poll_req,
    input logic [ADDR_W-1:0] poll_addr,
    input logic              poll_ack,
    input logic              done,
    input logic              fail,
    input logic              rty_full,
    input fpp_state_e        state_q
);

    // R2: the program command is followed at once by a data write.
    assert_data_after_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UNLK2) |=> (fl_we && state_q == ST_BURST));

    // R3: no data write carries the erased value.
    assert_no_erased_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_we && state_q == ST_BURST) |-> (fl_wdata != ERASED_BYTE));

    // R5: request and address held until acknowledged.
    assert_poll_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_req && !poll_ack) |=> (poll_req && $stable(poll_addr)));

    // R5: bus quiet while waiting for completion.
    assert_poll_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        poll_req |-> (!fl_we && !fl_re));

    // R9: a failed page only when the retry budget was spent.
    assert_fail_on_budget_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fail) |-> $past(rty_full));

    // R10: done lasts a single cycle.
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind flash_page_prog fpp_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fl_we     (fl_we),
    .fl_re     (fl_re),
    .fl_wdata  (fl_wdata),
    .poll_req  (poll_req),
    .poll_addr (poll_addr),
    .poll_ack  (poll_ack),
    .done      (done),
    .fail      (fail),
    .rty_full  (rty_full),
    .state_q   (state_q)
);

// File: tb/flash_page_prog_tb.sv
`timescale 1ns/1ps
// Directed bench: flash model with per-byte weak-cell injection,
// completion responder, and one task per scenario.
module flash_page_prog_tb;

    localparam int AW = 16;
    localparam int PB = 16;
    localparam int MR = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] page_base = '0;
    logic [3:0]    src_idx;
    logic [7:0]    src_data;
    logic          fl_we, fl_re;
    logic [AW-1:0] fl_addr;
    logic [7:0]    fl_wdata, fl_rdata;
    logic          poll_req;
    logic [AW-1:0] poll_addr;
    logic          poll_ack;
    logic          done, fail;
    logic [11:0]   fail_page;

    logic [7:0]  src_mem [PB];
    logic [7:0]  mem [64];
    int          prog_cnt [64];
    int          weak_lim [64];
    int          first_idx [64];
    logic        erase_req = 1'b0;
    logic [11:0] exp_page = '0;

    int wr_n = 0, unl_n = 0, poll_n = 0, rd_n = 0;
    int seq_err = 0, rd_err = 0, poll_err = 0, page_err = 0;
    int cmd_st = 0;
    logic first_pend = 1'b0;
    logic poll_seen = 1'b0;
    logic [AW-1:0] poll_last = '0;
    logic [3:0] rd_exp = '0;
    int pc = 0;

    int checks = 0, fails = 0;
    int s_wr, s_unl, s_poll, s_rd, s_seq, s_rde, s_pe, s_pg;

    always #2 clk = ~clk;

    flash_page_prog #(.ADDR_W(AW), .PAGE_BYTES(PB), .MAX_RETRY(MR)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .page_base(page_base),
        .src_idx(src_idx), .src_data(src_data),
        .fl_we(fl_we), .fl_re(fl_re), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .fl_rdata(fl_rdata), .poll_req(poll_req), .poll_addr(poll_addr),
        .poll_ack(poll_ack), .done(done), .fail(fail), .fail_page(fail_page)
    );

    assign src_data = src_mem[src_idx];
    assign fl_rdata = mem[fl_addr[5:0]];

    // Flash model and bus monitor.
    always @(posedge clk) begin
        if (erase_req) begin
            for (int i = 0; i < 64; i++) begin
                mem[i]      <= 8'hFF;
                prog_cnt[i] <= 0;
            end
        end else begin
            if (fl_we) begin
                if (cmd_st == 0 && fl_addr == 16'h5555 && fl_wdata == 8'hAA) cmd_st <= 1;
                else if (cmd_st == 1 && fl_addr == 16'h2AAA && fl_wdata == 8'h55) cmd_st <= 2;
                else if (cmd_st == 2 && fl_addr == 16'h5555 && fl_wdata == 8'hA0) begin
                    cmd_st     <= 3;
                    unl_n      <= unl_n + 1;
                    first_pend <= 1'b1;
                    rd_exp     <= '0;
                end else if (cmd_st == 3) begin
                    if (fl_addr[15:4] != exp_page) page_err <= page_err + 1;
                    if (first_pend) first_idx[(unl_n - 1) % 64] <= int'(fl_addr[3:0]);
                    first_pend <= 1'b0;
                    wr_n <= wr_n + 1;
                    prog_cnt[fl_addr[5:0]] <= prog_cnt[fl_addr[5:0]] + 1;
                    if (prog_cnt[fl_addr[5:0]] >= weak_lim[fl_addr[5:0]])
                        mem[fl_addr[5:0]] <= mem[fl_addr[5:0]] & fl_wdata;
                end else begin
                    seq_err <= seq_err + 1;
                end
            end
            if (poll_req) begin
                if (fl_we || fl_re) poll_err <= poll_err + 1;
                if (!poll_seen) begin
                    poll_n    <= poll_n + 1;
                    poll_last <= poll_addr;
                    poll_seen <= 1'b1;
                    cmd_st    <= 0;
                end
            end else begin
                poll_seen <= 1'b0;
            end
            if (fl_re) begin
                rd_n <= rd_n + 1;
                if (fl_addr[3:0] != rd_exp) rd_err <= rd_err + 1;
                rd_exp <= fl_addr[3:0] + 4'd1;
            end
        end
    end

    // Completion detector stand-in: acknowledges three cycles after request.
    always @(negedge clk) begin
        if (!rst_n || !poll_req) begin
            poll_ack <= 1'b0;
            pc       <= 0;
        end else if (pc == 2) begin
            poll_ack <= 1'b1;
            pc       <= 0;
        end else begin
            poll_ack <= 1'b0;
            pc       <= pc + 1;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic erase_all();
        @(negedge clk); erase_req = 1'b1;
        @(negedge clk); erase_req = 1'b0;
        for (int i = 0; i < 64; i++) weak_lim[i] = 0;
    endtask

    task automatic snap();
        s_wr = wr_n; s_unl = unl_n; s_poll = poll_n; s_rd = rd_n;
        s_seq = seq_err; s_rde = rd_err; s_pe = poll_err; s_pg = page_err;
    endtask

    task automatic run_page(input logic [AW-1:0] base, input bit poke,
                            output logic f, output logic [11:0] fp, output logic pulse_ok);
        int n;
        @(negedge clk);
        page_base = base; exp_page = base[15:4]; start = 1'b1;
        @(negedge clk);
        start = 1'b0; page_base = 16'h0300;
        n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
            start = (poke && n == 30);
        end
        start = 1'b0;
        chk("R10 done reached", longint'(done), 1);
        f = fail; fp = fail_page;
        @(negedge clk);
        pulse_ok = !done;
    endtask

    task automatic common_checks(input string tag);
        chk({tag, " R2 command order"}, seq_err - s_seq, 0);
        chk({tag, " R7 read order"}, rd_err - s_rde, 0);
        chk({tag, " R5 bus quiet during poll"}, poll_err - s_pe, 0);
        chk({tag, " R11 writes inside page"}, page_err - s_pg, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 done", done, 0);
        chk("R1 fail", fail, 0);
        chk("R1 fl_we", fl_we, 0);
        chk("R1 fl_re", fl_re, 0);
        chk("R1 poll_req", poll_req, 0);
    endtask

    task automatic t_basic();
        logic f, p; logic [11:0] fp;
        erase_all();
        for (int i = 0; i < PB; i++) src_mem[i] = 8'((i * 37 + 5) & 255);
        src_mem[3] = 8'hFF; src_mem[15] = 8'hFF;
        snap();
        run_page(16'h0100, 1'b0, f, fp, p);
        chk("R10 pass result", f, 0);
        chk("R10 single pulse", p, 1);
        chk("R4 one prefix", unl_n - s_unl, 1);
        chk("R3 skipped erased bytes", wr_n - s_wr, 14);
        chk("R5 one poll", poll_n - s_poll, 1);
        chk("R5 poll on last written", poll_last, 16'h010E);
        chk("R7 full read-back", rd_n - s_rd, 16);
        for (int i = 0; i < PB; i++) chk("R3 page content", mem[i], src_mem[i]);
        common_checks("basic");
    endtask

    task automatic t_all_erased();
        logic f, p; logic [11:0] fp;
        for (int i = 0; i < PB; i++) src_mem[i] = 8'hFF;
        snap();
        run_page(16'h0110, 1'b0, f, fp, p);
        chk("R6 result", f, 0);
        chk("R6 no prefix", unl_n - s_unl, 0);
        chk("R6 no writes", wr_n - s_wr, 0);
        chk("R6 no poll", poll_n - s_poll, 0);
        chk("R6 read-back still runs", rd_n - s_rd, 16);
        common_checks("erased");
    endtask

    task automatic t_weak_retry();
        logic f, p; logic [11:0] fp;
        for (int i = 0; i < PB; i++) src_mem[i] = 8'(i);
        weak_lim[6'h29] = 2;
        snap();
        run_page(16'h0120, 1'b1, f, fp, p);
        chk("R8 result", f, 0);
        chk("R11 start ignored, attempts", unl_n - s_unl, 3);
        chk("R8 attempt 2 start index", first_idx[s_unl + 1], 9);
        chk("R8 attempt 3 start index", first_idx[s_unl + 2], 9);
        chk("R8 total writes", wr_n - s_wr, 30);
        chk("R7 stop at first mismatch", rd_n - s_rd, 36);
        chk("R5 polls", poll_n - s_poll, 3);
        common_checks("weak");
    endtask

    task automatic t_exhaust();
        logic f, p; logic [11:0] fp;
        for (int i = 0; i < PB; i++) src_mem[i] = 8'(8'h40 + i);
        weak_lim[6'h35] = 1000;
        snap();
        run_page(16'h0130, 1'b0, f, fp, p);
        chk("R9 fail flag", f, 1);
        chk("R9 fail page", fp, 12'h013);
        chk("R9 attempts", unl_n - s_unl, 17);
        chk("R9 reads", rd_n - s_rd, 102);
        chk("R10 single pulse", p, 1);
        common_checks("exhaust");
    endtask

    task automatic t_counter_reset();
        logic f, p; logic [11:0] fp;
        erase_all();
        for (int i = 0; i < PB; i++) src_mem[i] = 8'(8'h10 + i);
        weak_lim[6'h0C] = 16;
        snap();
        run_page(16'h0100, 1'b0, f, fp, p);
        chk("R11 retry count restarts, pass on last attempt", f, 0);
        chk("R9 attempts at limit", unl_n - s_unl, 17);
        for (int i = 0; i < PB; i++) chk("R3 content after retries", mem[i], src_mem[i]);
        common_checks("limit");
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) weak_lim[i] = 0;
        for (int i = 0; i < 64; i++) first_idx[i] = 0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_basic();
        t_all_erased();
        t_weak_retry();
        t_exhaust();
        t_counter_reset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule